// File: doc/BRIEF.md
# Indirect Object Memory Access Window

This block gives a host a narrow register window onto internal storage objects that are too large to map directly. The host first writes a 32-bit control word. The word names the target object, sets a 32-bit word address, and sets two independent auto-increment enables, one for reads and one for writes. The host then moves data through two 16-bit data registers. One data register carries the lower half of the addressed 32-bit word and the other carries the upper half.

Two objects are backed by storage. Object 1 is a 4096-byte shared memory organised as 32-bit words. Object 2 is a bank of 64 sixteen-bit registers. For object 2 the address picks a register directly, and only the lower data register carries data. A full 32-bit write to the shared memory is completed by the upper-half access: a lower-half write is only staged until then. The address moves on only after an upper-half access, so a lower/upper pair always stays on one word and a streaming host can walk through memory without rewriting the control word.

Top module: `obj_window`

## Requirements
- R1: After reset the control register reads back as 0x00000000 and every register of object 2 reads as zero.
- R2: Control word layout: bit 25 enables increment after an upper-half read, bit 24 enables increment after an upper-half write, bits 18:16 select the object, and bits 15:0 hold the word address. A control read returns these fields with the current address, and all other bits read as zero.
- R3: With object 1 selected, a lower-half write (offset 0x164) is staged and an upper-half write (offset 0x166) stores {upper, staged lower} into the addressed word. Lower-half and upper-half reads return bits 15:0 and 31:16 of that word in hostRdata[15:0], with hostRdata[31:16] zero.
- R4: An upper-half write to object 1 with no staged lower half changes only bits 31:16 of the word.
- R5: A write to the upper-half register advances the address by one when bit 24 is set. A lower-half write never moves the address.
- R6: A read of the upper-half register advances the address by one when bit 25 is set. A lower-half read never moves the address.
- R7: A write to the control register (offset 0x160) discards any staged lower half.
- R8: With object 2 selected, the address selects a register. A lower-half write stores the value at once and a lower-half read returns it. Upper-half reads return zero and upper-half writes change nothing.
- R9: Object selections 0 and 3 to 7 read as zero, and writes to them change neither object 1 nor object 2.
- R10: The storage index is the address modulo the object size (1024 words or 64 registers). The 16-bit address held in the control register wraps from 0xFFFF to 0x0000.
- R11: A read of any offset other than 0x160, 0x164 or 0x166 returns zero, and a write there has no effect.
- R12: Read data appears on hostRdata together with a one-cycle hostRvalid pulse in the cycle after the read request. hostRvalid stays low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request for one cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 12 | Byte offset of the window register |
| hostWdata | input | 32 | Write data; data registers use bits 15:0 |
| hostRdata | output | 32 | Registered read data |
| hostRvalid | output | 1 | Read data valid pulse |

## Verification
The shared memory is first swept over every one of its 1024 words with a distinct arithmetic pattern in each half, using write auto-increment. It is then read back with read auto-increment. This separates correct half placement from swapped halves and from stuck or skipped address steps. The register bank gets the same treatment. Interleaved writes to the ignored upper half show whether the bank advances without corrupting data. Targeted sequences then examine the remaining corner cases:
- a lone upper-half write, against a merged lower/upper write;
- a staged lower half dropped by a control rewrite;
- addresses beyond the object size, and the 0xFFFF-to-0x0000 step;
- writes to object selections without storage, which must leave both real objects untouched.

// File: rtl/obj_window_pkg.sv
package obj_window_pkg;

  localparam int HOST_AW = 12;

  localparam logic [HOST_AW-1:0] OFS_CTL = 12'h160;
  localparam logic [HOST_AW-1:0] OFS_LO  = 12'h164;
  localparam logic [HOST_AW-1:0] OFS_HI  = 12'h166;

  localparam int BIT_RD_INC = 25;
  localparam int BIT_WR_INC = 24;

  localparam logic [2:0] OBJ_SHM  = 3'd1;
  localparam logic [2:0] OBJ_REGS = 3'd2;

  // strobes from control to datapath, valid in the cycle of the host access
  typedef struct packed {
    logic readAny;   // any read request (drives rvalid)
    logic readCtl;   // control register read
    logic readLo;    // lower-half read
    logic readHi;    // upper-half read
    logic holdLo;    // stage lower half for shared memory
    logic writeReg;  // lower-half write into register bank
    logic writeHi;   // upper-half write into shared memory
    logic mergeLo;   // staged lower half is valid for this upper write
  } strobe_t;

endpackage

// File: rtl/obj_window_ctrl.sv
module obj_window_ctrl
  import obj_window_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWdata,
  output strobe_t            stb,
  output logic [2:0]         objSel,
  output logic [15:0]        wordAddr,
  output logic [31:0]        ctlView
);

  logic rdInc, wrInc, pendLo;
  logic hitCtl, hitLo, hitHi;
  logic rdReq, wrReq;
  logic [15:0] nextAddr;
  logic unusedCtlBits;

  assign hitCtl = (hostAddr == OFS_CTL);
  assign hitLo  = (hostAddr == OFS_LO);
  assign hitHi  = (hostAddr == OFS_HI);
  assign rdReq  = hostValid & ~hostWrite;
  assign wrReq  = hostValid &  hostWrite;
  assign nextAddr = wordAddr + 16'd1;

  assign unusedCtlBits = ^{hostWdata[31:26], hostWdata[23:19]};

  always_comb begin
    stb          = '0;
    stb.readAny  = rdReq;
    stb.readCtl  = rdReq & hitCtl;
    stb.readLo   = rdReq & hitLo;
    stb.readHi   = rdReq & hitHi;
    stb.holdLo   = wrReq & hitLo & (objSel == OBJ_SHM);
    stb.writeReg = wrReq & hitLo & (objSel == OBJ_REGS);
    stb.writeHi  = wrReq & hitHi & (objSel == OBJ_SHM);
    stb.mergeLo  = pendLo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdInc    <= 1'b0;
      wrInc    <= 1'b0;
      objSel   <= '0;
      wordAddr <= '0;
      pendLo   <= 1'b0;
    end else if (wrReq && hitCtl) begin
      rdInc    <= hostWdata[BIT_RD_INC];
      wrInc    <= hostWdata[BIT_WR_INC];
      objSel   <= hostWdata[18:16];
      wordAddr <= hostWdata[15:0];
      pendLo   <= 1'b0;
    end else begin
      if (stb.holdLo) pendLo <= 1'b1;
      if (wrReq && hitHi) begin
        pendLo <= 1'b0;
        if (wrInc) wordAddr <= nextAddr;
      end
      if (rdReq && hitHi && rdInc) wordAddr <= nextAddr;
    end
  end

  assign ctlView = {6'b0, rdInc, wrInc, 5'b0, objSel, wordAddr};

endmodule

// File: rtl/obj_window_dp.sv
module obj_window_dp
  import obj_window_pkg::*;
#(
  parameter int SHM_WORDS = 1024,
  parameter int REG_COUNT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [2:0]  objSel,
  input  logic [15:0] wordAddr,
  input  logic [15:0] wdata,
  input  logic [31:0] ctlView,
  output logic [31:0] hostRdata,
  output logic        hostRvalid
);

  localparam int SW = $clog2(SHM_WORDS);
  localparam int RW = $clog2(REG_COUNT);

  logic [31:0] shm     [SHM_WORDS];
  logic [15:0] regBank [REG_COUNT];
  logic [15:0] loHold;
  logic [SW-1:0] shmIdx;
  logic [RW-1:0] regIdx;
  logic [31:0] rdNext;
  logic unusedAddrBits;

  assign shmIdx = wordAddr[SW-1:0];
  assign regIdx = wordAddr[RW-1:0];
  assign unusedAddrBits = ^wordAddr;

  // shared memory: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (stb.writeHi) begin
      shm[shmIdx][31:16] <= wdata;
      if (stb.mergeLo) shm[shmIdx][15:0] <= loHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           loHold <= '0;
    else if (stb.holdLo) loHold <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regBank[i] <= '0;
    end else if (stb.writeReg) begin
      regBank[regIdx] <= wdata;
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.readCtl) begin
      rdNext = ctlView;
    end else if (stb.readLo) begin
      if (objSel == OBJ_SHM)       rdNext = {16'b0, shm[shmIdx][15:0]};
      else if (objSel == OBJ_REGS) rdNext = {16'b0, regBank[regIdx]};
    end else if (stb.readHi) begin
      if (objSel == OBJ_SHM)       rdNext = {16'b0, shm[shmIdx][31:16]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata  <= '0;
      hostRvalid <= 1'b0;
    end else begin
      hostRvalid <= stb.readAny;
      if (stb.readAny) hostRdata <= rdNext;
    end
  end

endmodule

// File: rtl/obj_window.sv
module obj_window
  import obj_window_pkg::*;
#(
  parameter int SHM_BYTES = 4096,
  parameter int REG_COUNT = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  output logic               hostRvalid
);

  localparam int SHM_WORDS = SHM_BYTES / 4;

  strobe_t     stb;
  logic [2:0]  objSel;
  logic [15:0] wordAddr;
  logic [31:0] ctlView;

  obj_window_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostValid(hostValid),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .stb      (stb),
    .objSel   (objSel),
    .wordAddr (wordAddr),
    .ctlView  (ctlView)
  );

  obj_window_dp #(
    .SHM_WORDS(SHM_WORDS),
    .REG_COUNT(REG_COUNT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .objSel    (objSel),
    .wordAddr  (wordAddr),
    .wdata     (hostWdata[15:0]),
    .ctlView   (ctlView),
    .hostRdata (hostRdata),
    .hostRvalid(hostRvalid)
  );

endmodule

// File: rtl/obj_window_checker.sv
module obj_window_checker
  import obj_window_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               hostValid,
  input logic               hostWrite,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [31:0]        hostRdata,
  input logic               hostRvalid,
  input logic [31:0]        ctlView
);

  logic rdReq, wrReq, mapped, noStore;
  assign rdReq   = hostValid & ~hostWrite;
  assign wrReq   = hostValid &  hostWrite;
  assign mapped  = (hostAddr == OFS_CTL) || (hostAddr == OFS_LO) || (hostAddr == OFS_HI);
  assign noStore = (ctlView[18:16] != OBJ_SHM) && (ctlView[18:16] != OBJ_REGS);

  a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> hostRvalid);

  a_r12_rvalid_only_for_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !hostRvalid);

  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !mapped) |=> (hostRdata == 32'd0));

  a_r5_low_write_keeps_addr: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && hostAddr == OFS_LO) |=> $stable(ctlView[15:0]));

  a_r5_high_write_advances: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && hostAddr == OFS_HI && ctlView[BIT_WR_INC])
      |=> (ctlView[15:0] == $past(ctlView[15:0]) + 16'd1));

  a_r6_high_read_advances: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && hostAddr == OFS_HI && ctlView[BIT_RD_INC])
      |=> (ctlView[15:0] == $past(ctlView[15:0]) + 16'd1));

  a_r6_low_read_keeps_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && hostAddr == OFS_LO) |=> $stable(ctlView[15:0]));

  a_r8_reg_high_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && hostAddr == OFS_HI && ctlView[18:16] == OBJ_REGS) |=> (hostRdata == 32'd0));

  a_r9_no_store_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (hostAddr == OFS_LO || hostAddr == OFS_HI) && noStore) |=> (hostRdata == 32'd0));

endmodule

bind obj_window obj_window_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostValid (hostValid),
  .hostWrite (hostWrite),
  .hostAddr  (hostAddr),
  .hostRdata (hostRdata),
  .hostRvalid(hostRvalid),
  .ctlView   (ctlView)
);

// File: tb/test_obj_window.sv
module test_obj_window;

  localparam int WORDS = 1024;
  localparam int REGS  = 64;
  localparam logic [11:0] A_CTL = 12'h160;
  localparam logic [11:0] A_LO  = 12'h164;
  localparam logic [11:0] A_HI  = 12'h166;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostRvalid;

  int checks = 0;
  int fails  = 0;
  bit lastRvalid;

  logic [31:0] shmModel [WORDS];
  logic [15:0] regModel [REGS];

  always #2.5 clk = ~clk;

  obj_window i_obj_window (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid)
  );

  function automatic logic [31:0] mkCtl(bit rdI, bit wrI, logic [2:0] obj, logic [15:0] addr);
    return {6'b0, rdI, wrI, 5'b0, obj, addr};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic hostWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
    lastRvalid = hostRvalid;
  endtask

  task automatic hostRd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b0; hostAddr = a;
    @(negedge clk);
    hostValid = 1'b0;
    lastRvalid = hostRvalid;
    d = hostRdata;
  endtask

  task automatic expectRd(logic [11:0] a, logic [31:0] exp, string tag);
    logic [31:0] d;
    hostRd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of control and register bank
    expectRd(A_CTL, 32'h0, "R1 control after reset");
    hostWr(A_CTL, mkCtl(1, 0, 3'd2, 16'd0));
    for (int i = 0; i < REGS; i++) begin
      expectRd(A_LO, 32'h0, "R1 register zero after reset");
      expectRd(A_HI, 32'h0, "R8 register high half zero");
    end

    // R2: control field layout
    hostWr(A_CTL, 32'hFFFF_FFFF);
    expectRd(A_CTL, 32'h0307_FFFF, "R2 control readback fields");

    // R3/R5: full sweep of shared memory with write increment
    hostWr(A_CTL, mkCtl(0, 1, 3'd1, 16'd0));
    for (int w = 0; w < WORDS; w++) begin
      logic [15:0] lo, hi;
      lo = 16'((w * 3 + 1) & 16'hFFFF);
      hi = 16'(w) ^ 16'hA5A5;
      hostWr(A_LO, {16'h0, lo});
      hostWr(A_HI, {16'h0, hi});
      shmModel[w] = {hi, lo};
    end
    expectRd(A_CTL, mkCtl(0, 1, 3'd1, 16'd1024), "R5 address after write sweep");

    // R3/R6: read back with read increment
    hostWr(A_CTL, mkCtl(1, 0, 3'd1, 16'd0));
    for (int w = 0; w < WORDS; w++) begin
      expectRd(A_LO, {16'h0, shmModel[w][15:0]}, "R3 lower half readback");
      expectRd(A_HI, {16'h0, shmModel[w][31:16]}, "R3 upper half readback");
    end
    expectRd(A_CTL, mkCtl(1, 0, 3'd1, 16'd1024), "R6 address after read sweep");

    // R6: low read does not move address
    hostWr(A_CTL, mkCtl(1, 0, 3'd1, 16'd9));
    hostRd(A_LO, d);
    expectRd(A_CTL, mkCtl(1, 0, 3'd1, 16'd9), "R6 lower read keeps address");

    // R10: address beyond object size wraps
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'h0400));
    expectRd(A_LO, {16'h0, shmModel[0][15:0]}, "R10 shared memory wrap");

    // R4/R10: lone upper write at 0xFFFF, address wraps to 0
    hostWr(A_CTL, mkCtl(0, 1, 3'd1, 16'hFFFF));
    hostWr(A_HI, 32'h0000_C3C3);
    shmModel[1023][31:16] = 16'hC3C3;
    expectRd(A_CTL, mkCtl(0, 1, 3'd1, 16'h0000), "R10 address wraps 0xFFFF to 0");
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'd1023));
    expectRd(A_LO, {16'h0, shmModel[1023][15:0]}, "R4 lower half kept");
    expectRd(A_HI, 32'h0000_C3C3, "R4 upper half written");

    // R5: lower write keeps address
    hostWr(A_CTL, mkCtl(0, 1, 3'd1, 16'd5));
    hostWr(A_LO, 32'h0000_7777);
    expectRd(A_CTL, mkCtl(0, 1, 3'd1, 16'd5), "R5 lower write keeps address");
    hostWr(A_HI, 32'h0000_6666);
    shmModel[5] = 32'h6666_7777;
    expectRd(A_CTL, mkCtl(0, 1, 3'd1, 16'd6), "R5 upper write advances");
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'd5));
    expectRd(A_LO, 32'h0000_7777, "R3 merged lower half");

    // R7: control write drops staged lower half
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'd7));
    hostWr(A_LO, 32'h0000_1234);
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'd7));
    hostWr(A_HI, 32'h0000_BEEF);
    shmModel[7][31:16] = 16'hBEEF;
    expectRd(A_LO, {16'h0, shmModel[7][15:0]}, "R7 staged lower half discarded");
    expectRd(A_HI, 32'h0000_BEEF, "R7 upper half written");

    // R8: register bank sweep, upper writes ignored
    hostWr(A_CTL, mkCtl(0, 1, 3'd2, 16'd0));
    for (int i = 0; i < REGS; i++) begin
      regModel[i] = 16'((i * 7 + 3) ^ 16'h5A00);
      hostWr(A_LO, {16'hFFFF, regModel[i]});
      hostWr(A_HI, 32'h0000_FFFF);
    end
    expectRd(A_CTL, mkCtl(0, 1, 3'd2, 16'd64), "R8 register address advance");
    hostWr(A_CTL, mkCtl(1, 0, 3'd2, 16'd0));
    for (int i = 0; i < REGS; i++) begin
      expectRd(A_LO, {16'h0, regModel[i]}, "R8 register readback");
      expectRd(A_HI, 32'h0, "R8 register upper half zero");
    end
    hostWr(A_CTL, mkCtl(0, 0, 3'd2, 16'h0043));
    expectRd(A_LO, {16'h0, regModel[3]}, "R10 register wrap");

    // R9: objects without storage
    for (int o = 0; o < 8; o++) begin
      if (o == 1 || o == 2) continue;
      hostWr(A_CTL, mkCtl(0, 0, 3'(o), 16'd2));
      hostWr(A_LO, 32'h0000_DEAD);
      hostWr(A_HI, 32'h0000_F00D);
      expectRd(A_LO, 32'h0, "R9 no-storage lower reads zero");
      expectRd(A_HI, 32'h0, "R9 no-storage upper reads zero");
    end
    hostWr(A_CTL, mkCtl(0, 0, 3'd1, 16'd2));
    expectRd(A_LO, {16'h0, shmModel[2][15:0]}, "R9 shared memory untouched low");
    expectRd(A_HI, {16'h0, shmModel[2][31:16]}, "R9 shared memory untouched high");
    hostWr(A_CTL, mkCtl(0, 0, 3'd2, 16'd2));
    expectRd(A_LO, {16'h0, regModel[2]}, "R9 register untouched");

    // R11/R12: unmapped offsets and read valid timing
    hostWr(A_CTL, mkCtl(1, 1, 3'd1, 16'd20));
    hostWr(12'h162, 32'hFFFF_FFFF);
    check(lastRvalid == 1'b0, "R12 no rvalid after write", 32'(lastRvalid), 32'd0);
    hostWr(12'h100, 32'h0000_0000);
    expectRd(A_CTL, mkCtl(1, 1, 3'd1, 16'd20), "R11 unmapped write ignored");
    check(lastRvalid == 1'b1, "R12 rvalid after read", 32'(lastRvalid), 32'd1);
    expectRd(12'h100, 32'h0, "R11 unmapped read zero");
    expectRd(12'h162, 32'h0, "R11 unmapped read zero near window");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule